// File: doc/BRIEF.md
# Multi-Cycle Subset Processor Core

This block is a 32-bit processor core that runs a small integer instruction subset: word load and store, five register-to-register operations (add, subtract, and, or, signed set-less-than), branch-on-equal and an absolute jump. One memory port carries both instruction fetches and data accesses. One ALU does all the arithmetic, including the program-counter increment and the branch-target sum.

A state-machine controller steps each instruction through three to five cycles. Results that must survive from one cycle to the next are held in internal registers: the fetched instruction word, the loaded memory word, both register operands and the ALU result. Branches and jumps finish in three cycles, stores and register operations in four, and loads in five.

The memory port is combinational on reads: the word at `memAddr` must appear on `memRData` within the same cycle. A write commits at the rising edge in any cycle where `memWe` is high. Addresses are byte addresses, and words are 4-byte aligned.

Top module: `mcyc_core`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, the core presents a fetch at byte address 0 with `memWe` low. Reset clears the program counter to 0 and places the controller in the fetch step.
- R2: Each instruction starts with a fetch cycle. In that cycle `memAddr` equals the program counter, the word on `memRData` is captured as the instruction, and the program counter advances by 4. The next fetch of straight-line code is at the following word address.
- R3: Opcode field bits [31:26] = 0 selects a register operation on rs (bits [25:21]) and rt (bits [20:16]), with the result written to rd (bits [15:11]). The function field (bits [5:0]) selects add = 0x20, subtract = 0x22, and = 0x24, or = 0x25, and set-less-than = 0x2A. The instruction takes 4 cycles.
- R4: Opcode 0x23 (load) reads the word at rs + the sign-extended bits [15:0] and writes it to rt. The instruction takes 5 cycles.
- R5: Opcode 0x2B (store) drives `memWe` high for exactly one cycle, the fourth, with `memAddr` = rs + the sign-extended offset and `memWData` = rt. The instruction takes 4 cycles.
- R6: Opcode 0x04 (branch-on-equal) takes 3 cycles. When rs equals rt, the next fetch is at (address of the branch + 4) + (sign-extended offset × 4). Otherwise the next fetch is at the branch address + 4.
- R7: Opcode 0x02 (jump) takes 3 cycles. The next fetch is at {upper 4 bits of the branch-address-plus-4, bits [25:0], 2'b00}.
- R8: Register 0 always reads as zero. A write that targets register 0 has no effect.
- R9: Set-less-than compares its operands as signed two's-complement numbers and writes 1 or 0.
- R10: Any opcode other than 0x00, 0x02, 0x04, 0x23 or 0x2B is a no-op that takes 2 cycles. It writes no register and no memory.
- R11: After the last cycle of any instruction, the controller returns to the fetch step. The load's write-back step is entered only from its memory-read step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| memAddr | output | 32 | Byte address for the shared memory port |
| memWData | output | 32 | Store data |
| memWe | output | 1 | Write strobe; the write commits at the rising edge |
| memRData | input | 32 | Combinational read data for `memAddr` |

## Verification
On every cycle, the embedded properties check the controller's stepping: decode always follows fetch, every final step returns to fetch, and write-back is reached only from the memory read. They also check that each fetch advances the program counter by 4, that the instruction register holds outside fetch, and that register-file writes land in the addressed entry. Cycle counts per instruction class, ALU results, the signedness of set-less-than, branch and jump targets, and the behaviour of register 0 and unknown opcodes can only be shown by the bench's programs. The bench observes them through the store traffic those programs produce: the address, the data and the exact cycle of each write.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int XLEN    = 32;
  localparam int REG_AW  = 5;
  localparam int OPC_W   = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_EXEC, ST_BRANCH, ST_JUMP,
    ST_MEMRD, ST_MEMWR, ST_RWB, ST_LWB
  } step_e;

  typedef enum logic [0:0] { SRCA_PC, SRCA_REG } srcA_e;
  typedef enum logic [1:0] { SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_IMMX4 } srcB_e;
  typedef enum logic [1:0] { OP_ADD, OP_SUB, OP_FUNCT } aluMode_e;
  typedef enum logic [1:0] { PCN_ALU, PCN_HELD, PCN_JUMP } pcNext_e;

  typedef struct packed {
    logic     irWe;
    logic     pcWe;
    logic     pcIfEqual;
    pcNext_e  pcSel;
    srcA_e    aSel;
    srcB_e    bSel;
    aluMode_e aluMode;
    logic     resWe;
    logic     opWe;
    logic     mdrWe;
    logic     memWe;
    logic     dataAddr;
    logic     regWe;
    logic     dstIsRd;
    logic     fromMdr;
  } strobes_t;

endpackage

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] opcode,
  output strobes_t         ctl
);

  step_e step, stepNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) step <= ST_FETCH;
    else       step <= stepNext;
  end

  always_comb begin
    stepNext = ST_FETCH;
    unique case (step)
      ST_FETCH:  stepNext = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OPC_LOAD || opcode == OPC_STORE) stepNext = ST_ADDR;
        else if (opcode == OPC_RTYPE)                  stepNext = ST_EXEC;
        else if (opcode == OPC_BEQ)                    stepNext = ST_BRANCH;
        else if (opcode == OPC_JUMP)                   stepNext = ST_JUMP;
        else                                           stepNext = ST_FETCH;
      end
      ST_ADDR:   stepNext = (opcode == OPC_LOAD) ? ST_MEMRD : ST_MEMWR;
      ST_EXEC:   stepNext = ST_RWB;
      ST_MEMRD:  stepNext = ST_LWB;
      default:   stepNext = ST_FETCH;
    endcase
  end

  always_comb begin
    ctl = '0;
    ctl.pcSel   = PCN_ALU;
    ctl.aSel    = SRCA_PC;
    ctl.bSel    = SRCB_FOUR;
    ctl.aluMode = OP_ADD;
    unique case (step)
      ST_FETCH: begin
        ctl.irWe = 1'b1;
        ctl.pcWe = 1'b1;
      end
      ST_DECODE: begin
        ctl.opWe  = 1'b1;
        ctl.bSel  = SRCB_IMMX4;
        ctl.resWe = 1'b1;
      end
      ST_ADDR: begin
        ctl.aSel  = SRCA_REG;
        ctl.bSel  = SRCB_IMM;
        ctl.resWe = 1'b1;
      end
      ST_EXEC: begin
        ctl.aSel    = SRCA_REG;
        ctl.bSel    = SRCB_REG;
        ctl.aluMode = OP_FUNCT;
        ctl.resWe   = 1'b1;
      end
      ST_BRANCH: begin
        ctl.aSel      = SRCA_REG;
        ctl.bSel      = SRCB_REG;
        ctl.aluMode   = OP_SUB;
        ctl.pcIfEqual = 1'b1;
        ctl.pcSel     = PCN_HELD;
      end
      ST_JUMP: begin
        ctl.pcWe  = 1'b1;
        ctl.pcSel = PCN_JUMP;
      end
      ST_MEMRD: begin
        ctl.dataAddr = 1'b1;
        ctl.mdrWe    = 1'b1;
      end
      ST_MEMWR: begin
        ctl.dataAddr = 1'b1;
        ctl.memWe    = 1'b1;
      end
      ST_RWB: begin
        ctl.regWe   = 1'b1;
        ctl.dstIsRd = 1'b1;
      end
      ST_LWB: begin
        ctl.regWe   = 1'b1;
        ctl.fromMdr = 1'b1;
      end
      default: ;
    endcase
  end

  // R11
  decode_follows_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_FETCH) |=> (step == ST_DECODE));

  // R11
  final_step_returns_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_BRANCH || step == ST_JUMP || step == ST_MEMWR ||
     step == ST_RWB || step == ST_LWB) |=> (step == ST_FETCH));

  // R11
  load_wb_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_LWB) |-> ($past(step) == ST_MEMRD));

endmodule

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn && wrAddr != '0) regs[wrAddr] <= wrData;
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

  // R8
  reg_write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0 && wrAddr == rdAddrA) |=>
      (rdAddrA != $past(wrAddr)) || (rdDataA == $past(wrData)));

endmodule

// File: rtl/mcyc_dpath.sv
module mcyc_dpath
  import mcyc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         ctl,
  output logic [OPC_W-1:0] opcode,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWData,
  output logic             memWe,
  input  logic [XLEN-1:0]  memRData
);

  typedef enum logic [2:0] { F_AND, F_OR, F_ADD, F_SUB, F_SLT, F_NONE } aluFn_e;

  logic [XLEN-1:0] pc, ir, mdr, opA, opB, aluHeld;
  logic [XLEN-1:0] rfA, rfB, immExt, aluIn1, aluIn2, aluRes, jumpDest, pcNext;
  logic [REG_AW-1:0] dstIdx;
  aluFn_e aluFn;
  logic aluZero, pcLoad;

  assign opcode = ir[31:26];
  assign immExt = {{(XLEN-16){ir[15]}}, ir[15:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      ir      <= '0;
      mdr     <= '0;
      opA     <= '0;
      opB     <= '0;
      aluHeld <= '0;
    end else begin
      if (pcLoad)    pc      <= pcNext;
      if (ctl.irWe)  ir      <= memRData;
      if (ctl.mdrWe) mdr     <= memRData;
      if (ctl.opWe)  begin
        opA <= rfA;
        opB <= rfB;
      end
      if (ctl.resWe) aluHeld <= aluRes;
    end
  end

  assign aluIn1 = (ctl.aSel == SRCA_REG) ? opA : pc;

  always_comb begin
    unique case (ctl.bSel)
      SRCB_REG:   aluIn2 = opB;
      SRCB_FOUR:  aluIn2 = XLEN'(4);
      SRCB_IMM:   aluIn2 = immExt;
      default:    aluIn2 = immExt << 2;
    endcase
  end

  always_comb begin
    unique case (ctl.aluMode)
      OP_ADD: aluFn = F_ADD;
      OP_SUB: aluFn = F_SUB;
      default: begin
        unique case (ir[5:0])
          FN_ADD:  aluFn = F_ADD;
          FN_SUB:  aluFn = F_SUB;
          FN_AND:  aluFn = F_AND;
          FN_OR:   aluFn = F_OR;
          FN_SLT:  aluFn = F_SLT;
          default: aluFn = F_NONE;
        endcase
      end
    endcase
  end

  always_comb begin
    unique case (aluFn)
      F_AND:   aluRes = aluIn1 & aluIn2;
      F_OR:    aluRes = aluIn1 | aluIn2;
      F_ADD:   aluRes = aluIn1 + aluIn2;
      F_SUB:   aluRes = aluIn1 - aluIn2;
      F_SLT:   aluRes = {{(XLEN-1){1'b0}}, $signed(aluIn1) < $signed(aluIn2)};
      default: aluRes = '0;
    endcase
  end

  assign aluZero  = (aluRes == '0);
  assign jumpDest = {pc[XLEN-1:XLEN-4], ir[25:0], 2'b00};

  always_comb begin
    unique case (ctl.pcSel)
      PCN_HELD: pcNext = aluHeld;
      PCN_JUMP: pcNext = jumpDest;
      default:  pcNext = aluRes;
    endcase
  end

  assign pcLoad = ctl.pcWe | (ctl.pcIfEqual & aluZero);

  assign memAddr  = ctl.dataAddr ? aluHeld : pc;
  assign memWData = opB;
  assign memWe    = ctl.memWe;
  assign dstIdx   = ctl.dstIsRd ? ir[15:11] : ir[20:16];

  mcyc_regfile #(.AW(REG_AW), .DW(XLEN)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .rdAddrA (ir[25:21]),
    .rdAddrB (ir[20:16]),
    .rdDataA (rfA),
    .rdDataB (rfB),
    .wrEn    (ctl.regWe),
    .wrAddr  (dstIdx),
    .wrData  (ctl.fromMdr ? mdr : aluHeld)
  );

  // R2
  fetch_advances_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.irWe |=> (pc == $past(pc) + XLEN'(4)));

  // R2
  ir_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.irWe |=> $stable(ir));

endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
  import mcyc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  output logic [31:0] memAddr,
  output logic [31:0] memWData,
  output logic        memWe,
  input  logic [31:0] memRData
);

  strobes_t         ctl;
  logic [OPC_W-1:0] opcode;

  mcyc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .ctl    (ctl)
  );

  mcyc_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .opcode   (opcode),
    .memAddr  (memAddr),
    .memWData (memWData),
    .memWe    (memWe),
    .memRData (memRData)
  );

  // R5
  store_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

endmodule

// File: tb/mcyc_core_tb.sv
module mcyc_core_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] memAddr, memWData, memRData;
  logic        memWe;

  logic [31:0] mem [256];
  logic        ldWe = 1'b0;
  logic [7:0]  ldIdx = '0;
  logic [31:0] ldData = '0;

  int cycIdx;
  int stCount;
  logic [31:0] stAddr [16];
  logic [31:0] stData [16];
  int          stCyc  [16];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcyc_core u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .memAddr  (memAddr),
    .memWData (memWData),
    .memWe    (memWe),
    .memRData (memRData)
  );

  assign memRData = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (ldWe)               mem[ldIdx] <= ldData;
    else if (rstN && memWe) mem[memAddr[9:2]] <= memWData;
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) cycIdx <= 0;
    else       cycIdx <= cycIdx + 1;
  end

  always @(negedge clk) begin
    if (!rstN) stCount <= 0;
    else if (memWe) begin
      if (stCount < 16) begin
        stAddr[stCount] <= memAddr;
        stData[stCount] <= memWData;
        stCyc[stCount]  <= cycIdx;
      end
      stCount <= stCount + 1;
    end
  end

  function automatic logic [31:0] encR(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] encJ(input logic [31:0] dest);
    return {6'h02, dest[27:2]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] byteAddr, input logic [31:0] data);
    ldIdx  = byteAddr[9:2];
    ldData = data;
    ldWe   = 1'b1;
    @(posedge clk);
    #1 ldWe = 1'b0;
  endtask

  task automatic clearMem();
    rstN = 1'b0;
    for (int i = 0; i < 256; i++) poke(32'(i * 4), 32'h0BAD0BAD);
  endtask

  task automatic startRun();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitCycle(input int n);
    while (cycIdx < n) @(negedge clk);
  endtask

  // R1 R2 R3 R4 R5 R9: loads, all five register operations, stores
  task automatic testArith();
    logic [31:0] a, b;
    logic [31:0] exp [6];
    a = 32'h8000_1234;
    b = 32'h0000_5678;
    exp[0] = a + b;
    exp[1] = a - b;
    exp[2] = a & b;
    exp[3] = a | b;
    exp[4] = 32'd1;
    exp[5] = 32'd0;
    clearMem();
    poke(32'h100, a);
    poke(32'h104, b);
    poke(32'h00, encI(6'h23, 0, 1, 16'h0100));
    poke(32'h04, encI(6'h23, 0, 2, 16'h0104));
    poke(32'h08, encR(1, 2, 3, 6'h20));
    poke(32'h0C, encR(1, 2, 4, 6'h22));
    poke(32'h10, encR(1, 2, 5, 6'h24));
    poke(32'h14, encR(1, 2, 6, 6'h25));
    poke(32'h18, encR(1, 2, 7, 6'h2A));
    poke(32'h1C, encR(2, 1, 8, 6'h2A));
    for (int i = 0; i < 6; i++) poke(32'(32 + 4 * i), encI(6'h2B, 0, 3 + i, 16'(32'h200 + 4 * i)));
    poke(32'h38, encJ(32'h38));
    // R1: reset state seen at the port
    check("R1 reset fetch address", memAddr, 32'h0);
    check("R1 reset write strobe", {31'd0, memWe}, 32'h0);
    startRun();
    #1;
    check("R1 first fetch address", memAddr, 32'h0);
    check("R1 first write strobe", {31'd0, memWe}, 32'h0);
    waitCycle(5);
    check("R2 second fetch address", memAddr, 32'h4);
    waitCycle(10);
    check("R2 third fetch address", memAddr, 32'h8);
    waitCycle(80);
    // R5: one strobe cycle per store
    check("R5 store count", 32'(stCount), 32'd6);
    // R4 R3 R5: 5 + 5 + 6*4 cycles before the first store's fourth cycle
    check("R4 R3 R5 first store cycle", 32'(stCyc[0]), 32'd37);
    check("R5 store spacing", 32'(stCyc[1] - stCyc[0]), 32'd4);
    check("R5 first store address", stAddr[0], 32'h200);
    check("R3 add", mem[8'h80], exp[0]);
    check("R3 sub", mem[8'h81], exp[1]);
    check("R3 and", mem[8'h82], exp[2]);
    check("R3 or", mem[8'h83], exp[3]);
    check("R9 slt negative below positive", mem[8'h84], exp[4]);
    check("R9 slt positive not below negative", mem[8'h85], exp[5]);
  endtask

  // R6 R7: taken and not-taken branch, forward jump
  task automatic testFlow();
    clearMem();
    poke(32'h100, 32'd7);
    poke(32'h104, 32'd7);
    poke(32'h00, encI(6'h23, 0, 1, 16'h0100));
    poke(32'h04, encI(6'h23, 0, 2, 16'h0104));
    poke(32'h08, encI(6'h04, 1, 2, 16'h0002));
    poke(32'h0C, encI(6'h2B, 0, 1, 16'h0200));
    poke(32'h10, encI(6'h2B, 0, 1, 16'h0204));
    poke(32'h14, encI(6'h04, 1, 0, 16'h0001));
    poke(32'h18, encJ(32'h28));
    poke(32'h1C, encI(6'h2B, 0, 1, 16'h0208));
    poke(32'h20, encI(6'h2B, 0, 1, 16'h0208));
    poke(32'h24, encI(6'h2B, 0, 1, 16'h0208));
    poke(32'h28, encI(6'h2B, 0, 2, 16'h020C));
    poke(32'h2C, encJ(32'h2C));
    startRun();
    waitCycle(13);
    check("R6 taken branch next fetch", memAddr, 32'h14);
    waitCycle(16);
    check("R6 not-taken branch next fetch", memAddr, 32'h18);
    waitCycle(19);
    check("R7 jump next fetch", memAddr, 32'h28);
    waitCycle(60);
    check("R6 R7 store count", 32'(stCount), 32'd1);
    check("R6 R7 store address", stAddr[0], 32'h20C);
    check("R6 R7 store cycle", 32'(stCyc[0]), 32'd22);
    check("R6 skipped word 0x200", mem[8'h80], 32'h0BAD0BAD);
    check("R6 skipped word 0x204", mem[8'h81], 32'h0BAD0BAD);
    check("R7 skipped word 0x208", mem[8'h82], 32'h0BAD0BAD);
    check("R6 R7 stored value", mem[8'h83], 32'd7);
  endtask

  // R8 R10 R4: register 0, unknown opcode, negative offsets
  task automatic testZeroAndNoop();
    clearMem();
    poke(32'h100, 32'h55);
    poke(32'h104, 32'h108);
    poke(32'h00, encI(6'h23, 0, 0, 16'h0100));
    poke(32'h04, {6'h3F, 5'd0, 5'd1, 16'h0100});
    poke(32'h08, encI(6'h2B, 0, 0, 16'h0200));
    poke(32'h0C, encI(6'h23, 0, 1, 16'h0104));
    poke(32'h10, encI(6'h23, 1, 2, 16'hFFF8));
    poke(32'h14, encI(6'h2B, 1, 2, 16'h00FC));
    poke(32'h18, encJ(32'h18));
    startRun();
    waitCycle(7);
    check("R10 no-op next fetch after 2 cycles", memAddr, 32'h8);
    waitCycle(60);
    check("R8 R10 store count", 32'(stCount), 32'd2);
    check("R8 register 0 stores zero", stData[0], 32'h0);
    check("R10 store cycle after no-op", 32'(stCyc[0]), 32'd10);
    check("R4 negative offset load data", stData[1], 32'h55);
    check("R4 base plus offset store address", stAddr[1], 32'h204);
    check("R4 second store cycle", 32'(stCyc[1]), 32'd24);
    check("R10 data word untouched", mem[8'h40], 32'h55);
  endtask

  initial begin
    testArith();
    testFlow();
    testZeroAndNoop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule